// File: doc/BRIEF.md
# Power-Fail Store and Recall Sequencer

This block decides when a memory with a nonvolatile shadow copies its volatile contents into the shadow (a store) and when it copies them back (a recall). It watches a supply-low flag, a hardware store request pin, SRAM write strobes and two software commands. It also takes an enable for automatic store on power loss. From these it produces start pulses and busy levels for the two copy engines, plus an SRAM access enable, a supply-low write inhibit and an active-low busy line. All timed phases are counted in clock cycles.

A dirty flag records whether the SRAM was written since the last completed store. Automatic and hardware stores are skipped when the array is clean. A supply loss always arms a recall, and that recall runs once the supply comes back. Reset is treated as power-up: a recall is pending, and the supply is assumed low until the synchroniser sees otherwise. A hardware request first leaves the SRAM open for a grace window, so a bus cycle already in flight can finish, and only then begins the store.

Top module: `nvs_pwr_ctrl`

## Requirements
- R1: After reset the block reports supply-low: `wr_inhibit`=1, `sram_en`=0, `store_busy`=`recall_busy`=0 and `hs_busy_n`=1. A recall is pending.
- R2: `vlow_async` passes through a two-flop synchroniser. While the synchronised level is 1, `wr_inhibit`=1 and `sram_en`=0, and SRAM writes do not mark the array dirty.
- R3: When the synchronised supply-low level falls while a recall is pending, a recall runs for exactly RECALL_CYC cycles. `recall_start` pulses in its first cycle, and `sram_en` is 0 throughout.
- R4: When the supply goes low with `autostore_en`=1 and the array dirty, a store of exactly STORE_CYC cycles runs. With the array clean, no store runs.
- R5: When the supply goes low with `autostore_en`=0, no store runs, whatever the dirty state. The dirty state is kept.
- R6: A low sample on `hs_req_n` requests a store. If the array is dirty, `sram_en` stays 1 for DELAY_CYC cycles, and then the store starts. `store_start` appears DELAY_CYC+2 cycles after the sampled request. If the array is clean, the request is dropped and no store runs.
- R7: A `sw_store` pulse starts a store even when the array is clean. A `sw_recall` pulse starts a recall.
- R8: The dirty flag is set by every accepted write (`sram_wr` while `sram_en`=1) and cleared when a store completes.
- R9: Requests that arrive during a store or recall are held and served afterwards. When several are pending, the order is: power-up recall, then hardware store, then software recall, then software store.
- R10: `store_busy` and `recall_busy` are never both 1. `hs_busy_n` is 0 exactly while either is 1. Each start signal is a one-cycle pulse in the first busy cycle.
- R11: Hardware and software requests that arrive while the supply is low are ignored, and pending store requests are dropped when the supply goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vlow_async | input | 1 | Supply below switch threshold, asynchronous |
| hs_req_n | input | 1 | Hardware store request, active low |
| sram_wr | input | 1 | SRAM write strobe |
| sw_store | input | 1 | Software store command pulse |
| sw_recall | input | 1 | Software recall command pulse |
| autostore_en | input | 1 | Allow automatic store on supply loss |
| store_start | output | 1 | One-cycle pulse at store begin |
| store_busy | output | 1 | Store in progress |
| recall_start | output | 1 | One-cycle pulse at recall begin |
| recall_busy | output | 1 | Recall in progress |
| wr_inhibit | output | 1 | Supply-low write and store inhibit |
| sram_en | output | 1 | SRAM access allowed |
| hs_busy_n | output | 1 | Active-low busy indication |

## Verification
The bench targets these cases:
- A hardware request on a clean array. A design that ignored the dirty flag would burn a store cycle.
- A write attempted while the supply is low. If it were accepted, the next hardware request would start a store it should skip.
- The grace window. It is measured from the request edge to `store_start`, so an off-by-one counter or a missing delay state shows as a wrong gap.
- A hardware request and a software recall landing in the same cycle, and a store command issued during a recall. Wrong priority shows as a swapped order. Dropped holding shows as a missing operation.
- Random mixes of writes, requests and power cycles, with and without automatic store. These are compared against a bench model of the dirty flag.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DELAY,
        ST_STORE,
        ST_RECALL,
        ST_INHIBIT
    } nvs_state_e;

    // pending requests, highest priority first
    typedef struct packed {
        logic pwr_rc;
        logic hw_st;
        logic sw_rc;
        logic sw_st;
    } nvs_pend_t;

    // acknowledges from the sequencer back to the request tracker
    typedef struct packed {
        logic pwr_rc;
        logic hw_st;
        logic sw_rc;
        logic sw_st;
        logic store_done;
    } nvs_ack_t;

    function automatic int unsigned nvs_max3(input int unsigned a,
                                             input int unsigned b,
                                             input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic logic nvs_is_timed(input nvs_state_e s);
        return (s == ST_DELAY) || (s == ST_STORE) || (s == ST_RECALL);
    endfunction

endpackage

// File: rtl/nvs_sync.sv
module nvs_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= RST_VAL;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= RST_VAL;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/nvs_req_track.sv
module nvs_req_track
    import nvs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      vlow_s,
    input  logic      hs_req_n,
    input  logic      sw_store,
    input  logic      sw_recall,
    input  logic      wr_ok,
    input  nvs_ack_t  ack,
    output nvs_pend_t pend,
    output logic      dirty
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pend.pwr_rc <= 1'b1;   // reset counts as power-up
            pend.hw_st  <= 1'b0;
            pend.sw_rc  <= 1'b0;
            pend.sw_st  <= 1'b0;
            dirty       <= 1'b0;
        end else begin
            // supply loss arms a recall and drops external requests
            if (vlow_s)          pend.pwr_rc <= 1'b1;
            else if (ack.pwr_rc) pend.pwr_rc <= 1'b0;

            if (vlow_s)          pend.hw_st <= 1'b0;
            else if (!hs_req_n)  pend.hw_st <= 1'b1;
            else if (ack.hw_st)  pend.hw_st <= 1'b0;

            if (vlow_s)          pend.sw_rc <= 1'b0;
            else if (sw_recall)  pend.sw_rc <= 1'b1;
            else if (ack.sw_rc)  pend.sw_rc <= 1'b0;

            if (vlow_s)          pend.sw_st <= 1'b0;
            else if (sw_store)   pend.sw_st <= 1'b1;
            else if (ack.sw_st)  pend.sw_st <= 1'b0;

            if (wr_ok)               dirty <= 1'b1;
            else if (ack.store_done) dirty <= 1'b0;
        end
    end
endmodule

// File: rtl/nvs_phase_timer.sv
module nvs_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit,
    output logic             first,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart) cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end

    assign first = (cnt == '0);
    assign done  = (cnt == limit - 1'b1);
endmodule

// File: rtl/nvs_seq_fsm.sv
module nvs_seq_fsm
    import nvs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       vlow_s,
    input  logic       autostore_en,
    input  nvs_pend_t  pend,
    input  logic       dirty,
    input  logic       t_done,
    output nvs_state_e state,
    output nvs_state_e nxt,
    output nvs_ack_t   ack
);
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        ack = '0;
        unique case (state)
            ST_IDLE: begin
                if (vlow_s) begin
                    nxt = (autostore_en && dirty) ? ST_STORE : ST_INHIBIT;
                end else if (pend.pwr_rc) begin
                    nxt        = ST_RECALL;
                    ack.pwr_rc = 1'b1;
                end else if (pend.hw_st) begin
                    ack.hw_st = 1'b1;
                    if (dirty) nxt = ST_DELAY;
                end else if (pend.sw_rc) begin
                    nxt       = ST_RECALL;
                    ack.sw_rc = 1'b1;
                end else if (pend.sw_st) begin
                    nxt       = ST_STORE;
                    ack.sw_st = 1'b1;
                end
            end
            ST_DELAY: begin
                if (t_done) nxt = ST_STORE;
            end
            ST_STORE: begin
                if (t_done) begin
                    ack.store_done = 1'b1;
                    nxt = vlow_s ? ST_INHIBIT : ST_IDLE;
                end
            end
            ST_RECALL: begin
                if (t_done) nxt = ST_IDLE;
            end
            ST_INHIBIT: begin
                if (!vlow_s) begin
                    nxt        = ST_RECALL;
                    ack.pwr_rc = 1'b1;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/nvs_pwr_ctrl.sv
module nvs_pwr_ctrl
    import nvs_pkg::*;
#(
    parameter int STORE_CYC  = 1250000,
    parameter int RECALL_CYC = 2000000,
    parameter int DELAY_CYC  = 7000,
    parameter int SYNC_STG   = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic vlow_async,
    input  logic hs_req_n,
    input  logic sram_wr,
    input  logic sw_store,
    input  logic sw_recall,
    input  logic autostore_en,
    output logic store_start,
    output logic store_busy,
    output logic recall_start,
    output logic recall_busy,
    output logic wr_inhibit,
    output logic sram_en,
    output logic hs_busy_n
);
    localparam int unsigned MAX_CYC = nvs_max3(STORE_CYC, RECALL_CYC, DELAY_CYC);
    localparam int CNT_W = $clog2(MAX_CYC + 1);

    logic             vlow_s;
    nvs_pend_t        pend;
    nvs_ack_t         ack;
    logic             dirty;
    nvs_state_e       state, nxt;
    logic             t_first, t_done, t_restart;
    logic [CNT_W-1:0] t_limit;

    nvs_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (vlow_async),
        .q   (vlow_s)
    );

    nvs_req_track u_req (
        .clk       (clk),
        .rst       (rst),
        .vlow_s    (vlow_s),
        .hs_req_n  (hs_req_n),
        .sw_store  (sw_store),
        .sw_recall (sw_recall),
        .wr_ok     (sram_wr && sram_en),
        .ack       (ack),
        .pend      (pend),
        .dirty     (dirty)
    );

    nvs_seq_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .vlow_s       (vlow_s),
        .autostore_en (autostore_en),
        .pend         (pend),
        .dirty        (dirty),
        .t_done       (t_done),
        .state        (state),
        .nxt          (nxt),
        .ack          (ack)
    );

    always_comb begin
        unique case (state)
            ST_DELAY:  t_limit = CNT_W'(DELAY_CYC);
            ST_STORE:  t_limit = CNT_W'(STORE_CYC);
            ST_RECALL: t_limit = CNT_W'(RECALL_CYC);
            default:   t_limit = CNT_W'(1);
        endcase
    end

    assign t_restart = (nxt != state) || !nvs_is_timed(state);

    nvs_phase_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .restart (t_restart),
        .limit   (t_limit),
        .first   (t_first),
        .done    (t_done)
    );

    assign store_busy   = (state == ST_STORE);
    assign recall_busy  = (state == ST_RECALL);
    assign store_start  = store_busy && t_first;
    assign recall_start = recall_busy && t_first;
    assign hs_busy_n    = !(store_busy || recall_busy);
    assign wr_inhibit   = vlow_s;
    assign sram_en      = ((state == ST_IDLE) || (state == ST_DELAY)) && !vlow_s;
endmodule

// File: rtl/nvs_pwr_ctrl_chk.sv
module nvs_pwr_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic vlow_async,
    input logic store_start,
    input logic store_busy,
    input logic recall_start,
    input logic recall_busy,
    input logic wr_inhibit,
    input logic sram_en
);
    AST_BUSY_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(store_busy && recall_busy)); // R10

    AST_NO_ACCESS_BUSY: assert property (@(posedge clk) disable iff (rst)
        (store_busy || recall_busy) |-> !sram_en); // R3

    AST_LOW_INHIBIT: assert property (@(posedge clk) disable iff (rst)
        ($past(vlow_async) && $past(vlow_async, 2)) |-> (wr_inhibit && !sram_en)); // R2

    AST_STORE_PULSE: assert property (@(posedge clk) disable iff (rst)
        store_start |=> (store_busy && !store_start)); // R10

    AST_RECALL_ENTRY: assert property (@(posedge clk) disable iff (rst)
        $rose(recall_busy) |-> recall_start); // R3
endmodule

bind nvs_pwr_ctrl nvs_pwr_ctrl_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .vlow_async   (vlow_async),
    .store_start  (store_start),
    .store_busy   (store_busy),
    .recall_start (recall_start),
    .recall_busy  (recall_busy),
    .wr_inhibit   (wr_inhibit),
    .sram_en      (sram_en)
);

// File: tb/sim_nvs_pwr_ctrl.sv
module sim_nvs_pwr_ctrl;
    localparam int ST = 12;
    localparam int RC = 16;
    localparam int DL = 6;
    localparam int QUIET = DL + ST + RC + 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic vlow_async = 1'b1;
    logic hs_req_n = 1'b1;
    logic sram_wr = 1'b0;
    logic sw_store = 1'b0;
    logic sw_recall = 1'b0;
    logic autostore_en = 1'b1;
    logic store_start, store_busy, recall_start, recall_busy;
    logic wr_inhibit, sram_en, hs_busy_n;

    always #4 clk = ~clk;

    nvs_pwr_ctrl #(.STORE_CYC(ST), .RECALL_CYC(RC), .DELAY_CYC(DL)) u0 (
        .clk(clk), .rst(rst), .vlow_async(vlow_async), .hs_req_n(hs_req_n),
        .sram_wr(sram_wr), .sw_store(sw_store), .sw_recall(sw_recall),
        .autostore_en(autostore_en), .store_start(store_start),
        .store_busy(store_busy), .recall_start(recall_start),
        .recall_busy(recall_busy), .wr_inhibit(wr_inhibit),
        .sram_en(sram_en), .hs_busy_n(hs_busy_n)
    );

    int n_chk = 0;
    int n_fail = 0;

    // observation counters
    int cyc = 0;
    int st_cnt = 0, rc_cnt = 0;
    int st_at = 0, rc_at = 0;
    int st_run = 0, rc_run = 0;
    int bad_st_len = 0, bad_rc_len = 0;
    int bad_access = 0, bad_hs = 0, bad_both = 0;

    always @(posedge clk) cyc++;

    always @(negedge clk) begin
        if (!rst) begin
            if (store_start)  begin st_cnt++; st_at = cyc; end
            if (recall_start) begin rc_cnt++; rc_at = cyc; end
            if (store_busy) st_run++;
            else if (st_run != 0) begin
                if (st_run != ST) bad_st_len++;
                st_run = 0;
            end
            if (recall_busy) rc_run++;
            else if (rc_run != 0) begin
                if (rc_run != RC) bad_rc_len++;
                rc_run = 0;
            end
            if ((store_busy || recall_busy) && sram_en) bad_access++;
            if (hs_busy_n == (store_busy || recall_busy)) bad_hs++;
            if (store_busy && recall_busy) bad_both++;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_writes(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); sram_wr = 1'b1;
        end
        @(negedge clk); sram_wr = 1'b0;
    endtask

    task automatic pulse_hw();
        @(negedge clk); hs_req_n = 1'b0;
        @(negedge clk); hs_req_n = 1'b1;
    endtask

    task automatic pulse_sws();
        @(negedge clk); sw_store = 1'b1;
        @(negedge clk); sw_store = 1'b0;
    endtask

    task automatic pulse_swr();
        @(negedge clk); sw_recall = 1'b1;
        @(negedge clk); sw_recall = 1'b0;
    endtask

    function automatic bit store_expected(input bit is_hw, input bit is_sw,
                                          input bit pwr_auto, input bit drt);
        if (is_sw) return 1'b1;
        if (is_hw || pwr_auto) return drt;
        return 1'b0;
    endfunction

    initial begin : watchdog
        #1000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        int s0, r0, req_cyc;
        bit mdirty;
        void'($urandom(32'd4242));
        tick(4);
        @(negedge clk); rst = 1'b0;
        tick(1);
        // R1 reset state
        chk(wr_inhibit == 1'b1, "R1 wr_inhibit", wr_inhibit, 1);
        chk(sram_en == 1'b0, "R1 sram_en", sram_en, 0);
        chk(!store_busy && !recall_busy && hs_busy_n, "R1 idle busy", {store_busy, recall_busy, hs_busy_n}, 1);

        // R3 power-up recall
        r0 = rc_cnt;
        @(negedge clk); vlow_async = 1'b0;
        tick(RC + 10);
        chk(rc_cnt - r0 == 1, "R3 power-up recall", rc_cnt - r0, 1);
        chk(sram_en == 1'b1, "R3 access after recall", sram_en, 1);
        mdirty = 1'b0;

        // R6 clean hardware request dropped
        s0 = st_cnt;
        pulse_hw();
        tick(QUIET);
        chk(st_cnt - s0 == 0, "R6 clean hw request", st_cnt - s0, 0);

        // R6 R8 dirty hardware request with grace window
        do_writes(3);
        s0 = st_cnt;
        @(negedge clk); hs_req_n = 1'b0; req_cyc = cyc;
        @(negedge clk); hs_req_n = 1'b1;
        tick(2);
        chk(sram_en == 1'b1 && !store_busy, "R6 grace access", sram_en, 1);
        tick(QUIET);
        chk(st_cnt - s0 == 1, "R6 dirty hw store", st_cnt - s0, 1);
        chk(st_at - req_cyc == DL + 2, "R6 grace length", st_at - req_cyc, DL + 2);

        // R8 dirty cleared by store
        s0 = st_cnt;
        pulse_hw();
        tick(QUIET);
        chk(st_cnt - s0 == 0, "R8 cleared after store", st_cnt - s0, 0);

        // R7 software store on clean array, software recall
        s0 = st_cnt; r0 = rc_cnt;
        pulse_sws();
        tick(QUIET);
        chk(st_cnt - s0 == 1, "R7 sw store", st_cnt - s0, 1);
        pulse_swr();
        tick(QUIET);
        chk(rc_cnt - r0 == 1, "R7 sw recall", rc_cnt - r0, 1);

        // R4 R2 R11 autostore then low-supply ignores
        do_writes(2);
        s0 = st_cnt; r0 = rc_cnt;
        autostore_en = 1'b1;
        @(negedge clk); vlow_async = 1'b1;
        tick(ST + 10);
        chk(st_cnt - s0 == 1, "R4 autostore dirty", st_cnt - s0, 1);
        chk(wr_inhibit == 1'b1 && sram_en == 1'b0, "R2 inhibit while low", wr_inhibit, 1);
        do_writes(3);
        pulse_hw();
        pulse_sws();
        pulse_swr();
        tick(5);
        chk(st_cnt - s0 == 1 && !store_busy, "R11 requests ignored when low", st_cnt - s0, 1);
        @(negedge clk); vlow_async = 1'b0;
        tick(QUIET);
        chk(rc_cnt - r0 == 1, "R3 recall after supply return", rc_cnt - r0, 1);
        chk(st_cnt - s0 == 1, "R11 no held store after return", st_cnt - s0, 1);
        pulse_hw();
        tick(QUIET);
        chk(st_cnt - s0 == 1, "R2 low writes not dirty", st_cnt - s0, 1);

        // R4 clean supply loss
        s0 = st_cnt;
        @(negedge clk); vlow_async = 1'b1;
        tick(20);
        @(negedge clk); vlow_async = 1'b0;
        tick(QUIET);
        chk(st_cnt - s0 == 0, "R4 clean no autostore", st_cnt - s0, 0);

        // R5 autostore disabled keeps dirty
        do_writes(1);
        s0 = st_cnt;
        autostore_en = 1'b0;
        @(negedge clk); vlow_async = 1'b1;
        tick(20);
        @(negedge clk); vlow_async = 1'b0;
        tick(QUIET);
        chk(st_cnt - s0 == 0, "R5 autostore disabled", st_cnt - s0, 0);
        pulse_hw();
        tick(QUIET);
        chk(st_cnt - s0 == 1, "R5 dirty kept", st_cnt - s0, 1);
        autostore_en = 1'b1;

        // R9 priority: hw store before sw recall
        do_writes(1);
        s0 = st_cnt; r0 = rc_cnt;
        @(negedge clk); hs_req_n = 1'b0; sw_recall = 1'b1;
        @(negedge clk); hs_req_n = 1'b1; sw_recall = 1'b0;
        tick(2 * QUIET);
        chk(st_cnt - s0 == 1 && rc_cnt - r0 == 1, "R9 both served", st_cnt - s0 + rc_cnt - r0, 2);
        chk(st_at < rc_at, "R9 hw before sw recall", st_at, rc_at);

        // R9 store request held during recall
        s0 = st_cnt; r0 = rc_cnt;
        pulse_swr();
        tick(4);
        pulse_sws();
        tick(2 * QUIET);
        chk(st_cnt - s0 == 1 && rc_cnt - r0 == 1, "R9 held request", st_cnt - s0, 1);
        chk(rc_at < st_at, "R9 held after recall", rc_at, st_at);
        mdirty = 1'b0;

        // random mix against model
        for (int it = 0; it < 60; it++) begin
            int act;
            bit es, au;
            int er;
            act = $urandom % 5;
            s0 = st_cnt; r0 = rc_cnt; er = 0; es = 1'b0;
            case (act)
                0: begin do_writes(1 + $urandom % 4); mdirty = 1'b1; end
                1: begin es = store_expected(1, 0, 0, mdirty); pulse_hw(); end
                2: begin es = store_expected(0, 1, 0, mdirty); pulse_sws(); end
                3: begin er = 1; pulse_swr(); end
                default: begin
                    au = 1'($urandom % 2);
                    autostore_en = au;
                    es = store_expected(0, 0, au, mdirty);
                    er = 1;
                    @(negedge clk); vlow_async = 1'b1;
                    tick(ST + 10);
                    do_writes(2);
                    @(negedge clk); vlow_async = 1'b0;
                end
            endcase
            if (es) mdirty = 1'b0;
            tick(QUIET);
            chk(st_cnt - s0 == int'(es), "R8 random store count", st_cnt - s0, int'(es));
            chk(rc_cnt - r0 == er, "R3 random recall count", rc_cnt - r0, er);
        end

        chk(bad_st_len == 0, "R4 store length", bad_st_len, 0);
        chk(bad_rc_len == 0, "R3 recall length", bad_rc_len, 0);
        chk(bad_access == 0, "R3 no access when busy", bad_access, 0);
        chk(bad_hs == 0, "R10 busy pin", bad_hs, 0);
        chk(bad_both == 0, "R10 exclusive busy", bad_both, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule